// File: doc/BRIEF.md
# Scanline and Frame Timing Generator

This block turns the master clock into video timing. A small prescaler divides the master clock into dot cycles. A dot counter tracks the horizontal position within the current line, and a line counter tracks the vertical position within the frame. From these counters the block produces the current line number and dot position, a visible-area flag, a vertical-blank flag, a field-parity bit and a window that stalls the CPU for a fixed stretch of every line.

Four controls set the frame shape. A region select chooses the 60 Hz or the 50 Hz line count. A height select chooses the shorter or the taller picture. An interlace enable adds one line to every second frame. A force-blank input hides the picture at once. The region, height and interlace controls are captured while reset is held and again each time the frame wraps, so a change in the middle of a frame takes effect in the next frame. When interlace is off, one line inside vertical blank is shortened by one dot in 60 Hz mode and lengthened by one dot in 50 Hz mode.

Top module: `scan_timing_gen`

## Requirements
- R1: A normal line is 1364 master clocks. The dot output counts 0 to 340, and it advances once every 4 master clocks.
- R2: `cpu_stall` is high for exactly 40 consecutive master clocks in every line. It rises at master clock 536 of the line (dot 134, first clock of that dot).
- R3: On line 0, both `visible` and `vblank` are low.
- R4: `visible` is high on lines 1 to 224 when `tall_pic` is 0, and on lines 1 to 239 when `tall_pic` is 1. When `force_blank` is 1, `visible` is 0 in the same cycle.
- R5: `vblank` is high from the line after the last visible line through the last line of the frame.
- R6: The last line of a frame is 261 when `pal_mode` is 0 and 311 when `pal_mode` is 1. The line after it is line 0.
- R7: `field` toggles at each frame wrap while interlace is enabled, and it is forced to 0 at a frame wrap while interlace is disabled. A frame that starts with `field` = 1 under interlace has one extra line, so its last line is 262 (60 Hz) or 312 (50 Hz).
- R8: With interlace off, line 240 lasts 1360 master clocks (dots 0 to 339) in 60 Hz mode and 1368 master clocks (dots 0 to 341) in 50 Hz mode. With interlace on, line 240 has normal length.
- R9: `pal_mode`, `tall_pic` and `interlace` are sampled while reset is held and on the clock that wraps the frame to line 0. A change at any other time has no effect until the next wrap.
- R10: While reset is held, `line` and `dot` are 0 and `field` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_mode | input | 1 | 0 selects the 262-line frame, 1 selects the 312-line frame |
| tall_pic | input | 1 | 0 selects 224 visible lines, 1 selects 239 |
| interlace | input | 1 | Enables field alternation and the extra line |
| force_blank | input | 1 | Clears the visible flag immediately |
| line | output | 9 | Current line within the frame |
| dot | output | 9 | Current dot within the line |
| visible | output | 1 | Active picture line and not blanked |
| vblank | output | 1 | Vertical blank in progress |
| cpu_stall | output | 1 | Mid-line CPU pause window |
| field | output | 1 | Interlace field parity |

## Verification
The assertions assume the line counts are larger than the visible heights, that the adjusted line falls inside vertical blank, and that the stall window ends before the shortest line ends. They also assume that reset lasts at least one clock. The bench uses reduced line and dot counts for the long frame sequences. Its parameters keep these same relations, and a second instance with default parameters measures the real line length and stall window. Mode inputs are changed one clock after an edge and in the middle of frames, so the capture at the frame wrap is exercised. `force_blank` toggles freely, because it is allowed to change at any time.

// File: rtl/scan_timing_pkg.sv
// Shared types for the scanline timing generator.
// Assumes nothing beyond the three frame-shape controls.
package scan_timing_pkg;

    // Frame shape captured at reset and at each frame wrap
    typedef struct packed {
        logic pal;    // 50 Hz line count
        logic tall;   // taller visible picture
        logic ilace;  // interlace enabled
    } frame_cfg_t;

endpackage

// File: rtl/stg_dot_div.sv
// Master-clock prescaler and dot counter.
// Divides the master clock by MCLK_PER_DOT and counts dots from 0 up to a
// last-dot value that the frame counter provides for the current line.
// Assumes MCLK_PER_DOT >= 2 and that last_dot changes only at line start.
module stg_dot_div #(
    parameter int MCLK_PER_DOT = 4,
    parameter int PH_W         = 2,
    parameter int DOT_W        = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DOT_W-1:0] last_dot,
    output logic [PH_W-1:0]  phase,
    output logic [DOT_W-1:0] dot,
    output logic             line_end
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(MCLK_PER_DOT - 1);

    // Final master clock of the final dot of the line
    assign line_end = (phase == PH_LAST) && (dot == last_dot);

    // Advance the prescaler and step the dot counter once per dot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            dot   <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
            dot   <= (dot == last_dot) ? '0 : dot + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/stg_frame_ctr.sv
// Line counter, field parity and frame-shape capture.
// Counts lines from 0 to the last line of the frame, then wraps to 0.
// Selects the dot limit for each line, including the one odd-length line
// used when interlace is off. Captures the mode inputs at reset and at wrap.
// Assumes LINES_60 and LINES_50 both exceed ADJ_LINE.
module stg_frame_ctr
    import scan_timing_pkg::*;
#(
    parameter int DOTS_PER_LINE = 341,
    parameter int LINES_60      = 262,
    parameter int LINES_50      = 312,
    parameter int ADJ_LINE      = 240,
    parameter int DOT_W         = 9,
    parameter int LINE_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  frame_cfg_t        cfg_in,
    output logic [LINE_W-1:0] line,
    output logic              field,
    output frame_cfg_t        cfg,
    output logic [DOT_W-1:0]  last_dot
);

    localparam logic [DOT_W-1:0]  DOT_NORM  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [DOT_W-1:0]  DOT_SHORT = DOT_W'(DOTS_PER_LINE - 2);
    localparam logic [DOT_W-1:0]  DOT_LONG  = DOT_W'(DOTS_PER_LINE);
    localparam logic [LINE_W-1:0] LAST_60   = LINE_W'(LINES_60 - 1);
    localparam logic [LINE_W-1:0] LAST_50   = LINE_W'(LINES_50 - 1);
    localparam logic [LINE_W-1:0] ADJ       = LINE_W'(ADJ_LINE);

    logic [LINE_W-1:0] last_line;
    logic              extended;

    // One extra line in every other interlaced frame
    assign extended = cfg.ilace && field;

    // Last line of the current frame from region and parity
    always_comb begin
        last_line = cfg.pal ? LAST_50 : LAST_60;
        if (extended) last_line = last_line + 1'b1;
    end

    // Dot limit for the current line: the odd-length line exists only without interlace
    always_comb begin
        last_dot = DOT_NORM;
        if (!cfg.ilace && (line == ADJ)) last_dot = cfg.pal ? DOT_LONG : DOT_SHORT;
    end

    // Step lines at each line end, wrap the frame, flip parity, capture modes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line  <= '0;
            field <= 1'b0;
            cfg   <= cfg_in;
        end else if (line_end) begin
            if (line == last_line) begin
                line  <= '0;
                field <= cfg.ilace ? ~field : 1'b0;
                cfg   <= cfg_in;
            end else begin
                line <= line + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stg_flags.sv
// Decodes counters into the visible, vertical-blank and CPU stall flags.
// The stall window covers master positions STALL_START up to
// STALL_START+STALL_LEN-1 within the line. Assumes the window fits in the
// shortest line.
module stg_flags
    import scan_timing_pkg::*;
#(
    parameter int MCLK_PER_DOT = 4,
    parameter int VIS_SHORT    = 224,
    parameter int VIS_TALL     = 239,
    parameter int STALL_START  = 536,
    parameter int STALL_LEN    = 40,
    parameter int PH_W         = 2,
    parameter int DOT_W        = 9,
    parameter int LINE_W       = 9,
    parameter int POS_W        = 11
) (
    input  logic [PH_W-1:0]   phase,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  frame_cfg_t        cfg,
    input  logic              force_blank,
    output logic              visible,
    output logic              vblank,
    output logic              stall
);

    localparam logic [LINE_W-1:0] VIS_S  = LINE_W'(VIS_SHORT);
    localparam logic [LINE_W-1:0] VIS_T  = LINE_W'(VIS_TALL);
    localparam logic [POS_W-1:0]  W_LO   = POS_W'(STALL_START);
    localparam logic [POS_W-1:0]  W_HI   = POS_W'(STALL_START + STALL_LEN);
    localparam logic [POS_W-1:0]  MPD    = POS_W'(MCLK_PER_DOT);

    logic [LINE_W-1:0] vis_last;
    logic [POS_W-1:0]  pos;

    // Last visible line for the captured height
    assign vis_last = cfg.tall ? VIS_T : VIS_S;

    // Picture lines start after the hidden line 0
    assign visible = (line != '0) && (line <= vis_last) && !force_blank;

    // Blank runs from after the picture to the end of the frame
    assign vblank  = (line > vis_last);

    // Master-clock position within the line
    assign pos = POS_W'(dot) * MPD + POS_W'(phase);

    // Fixed mid-line CPU pause
    assign stall = (pos >= W_LO) && (pos < W_HI);

endmodule

// File: rtl/scan_timing_gen.sv
// Scanline and frame timing generator, top level.
// Connects the dot divider, frame counter and flag decoder. All outputs
// follow registered counters; visible also follows force_blank directly.
// Assumes a free-running master clock and synchronous active-low reset.
module scan_timing_gen
    import scan_timing_pkg::*;
#(
    parameter int MCLK_PER_DOT  = 4,
    parameter int DOTS_PER_LINE = 341,
    parameter int LINES_60      = 262,
    parameter int LINES_50      = 312,
    parameter int VIS_SHORT     = 224,
    parameter int VIS_TALL      = 239,
    parameter int ADJ_LINE      = 240,
    parameter int STALL_START   = 536,
    parameter int STALL_LEN     = 40,
    parameter int DOT_W         = 9,
    parameter int LINE_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_mode,
    input  logic              tall_pic,
    input  logic              interlace,
    input  logic              force_blank,
    output logic [LINE_W-1:0] line,
    output logic [DOT_W-1:0]  dot,
    output logic              visible,
    output logic              vblank,
    output logic              cpu_stall,
    output logic              field
);

    localparam int PH_W  = $clog2(MCLK_PER_DOT);
    localparam int POS_W = $clog2((DOTS_PER_LINE + 1) * MCLK_PER_DOT + 1);

    frame_cfg_t        cfg_in;
    frame_cfg_t        cfg;
    logic [PH_W-1:0]   phase;
    logic [DOT_W-1:0]  last_dot;
    logic              line_end;

    // Bundle the mode pins for capture
    assign cfg_in = '{pal: pal_mode, tall: tall_pic, ilace: interlace};

    stg_dot_div #(
        .MCLK_PER_DOT (MCLK_PER_DOT),
        .PH_W         (PH_W),
        .DOT_W        (DOT_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_dot (last_dot),
        .phase    (phase),
        .dot      (dot),
        .line_end (line_end)
    );

    stg_frame_ctr #(
        .DOTS_PER_LINE (DOTS_PER_LINE),
        .LINES_60      (LINES_60),
        .LINES_50      (LINES_50),
        .ADJ_LINE      (ADJ_LINE),
        .DOT_W         (DOT_W),
        .LINE_W        (LINE_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .cfg_in   (cfg_in),
        .line     (line),
        .field    (field),
        .cfg      (cfg),
        .last_dot (last_dot)
    );

    stg_flags #(
        .MCLK_PER_DOT (MCLK_PER_DOT),
        .VIS_SHORT    (VIS_SHORT),
        .VIS_TALL     (VIS_TALL),
        .STALL_START  (STALL_START),
        .STALL_LEN    (STALL_LEN),
        .PH_W         (PH_W),
        .DOT_W        (DOT_W),
        .LINE_W       (LINE_W),
        .POS_W        (POS_W)
    ) u_flags (
        .phase       (phase),
        .dot         (dot),
        .line        (line),
        .cfg         (cfg),
        .force_blank (force_blank),
        .visible     (visible),
        .vblank      (vblank),
        .stall       (cpu_stall)
    );

endmodule

// File: rtl/scan_timing_chk.sv
// Property checker for the timing generator, bound to every instance.
// Assumes reset is held for at least one clock before release.
module scan_timing_chk #(
    parameter int MCLK_PER_DOT = 4,
    parameter int LINES_60     = 262,
    parameter int LINES_50     = 312,
    parameter int STALL_START  = 536,
    parameter int STALL_LEN    = 40,
    parameter int DOT_W        = 9,
    parameter int LINE_W       = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_blank,
    input logic [LINE_W-1:0] line,
    input logic [DOT_W-1:0]  dot,
    input logic              visible,
    input logic              vblank,
    input logic              cpu_stall,
    input logic              field
);

    localparam int MIN_LAST = ((LINES_60 < LINES_50) ? LINES_60 : LINES_50) - 1;
    localparam logic [DOT_W-1:0] STALL_DOT = DOT_W'(STALL_START / MCLK_PER_DOT);

    logic [15:0] run_cnt;

    // Length of the current stall run
    always_ff @(posedge clk) begin
        if (!rst_n)         run_cnt <= '0;
        else if (cpu_stall) run_cnt <= run_cnt + 1'b1;
        else                run_cnt <= '0;
    end

    // R1
    dot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dot) |-> (dot == '0) || (dot == $past(dot) + 1'b1));

    // R6
    line_at_dot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line) |-> (dot == '0));

    // R6
    wrap_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line == '0 && $past(line) != '0) |-> ($past(line) >= LINE_W'(MIN_LAST)));

    // R2
    stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> (dot == STALL_DOT));

    // R2
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> (run_cnt == 16'(STALL_LEN)));

    // R3
    line0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line == '0) |-> (!visible && !vblank));

    // R4
    blank_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_blank |-> !visible);

    // R5
    vis_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> !visible);

    // R7
    field_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> (line == '0 && dot == '0));

endmodule

bind scan_timing_gen scan_timing_chk #(
    .MCLK_PER_DOT (MCLK_PER_DOT),
    .LINES_60     (LINES_60),
    .LINES_50     (LINES_50),
    .STALL_START  (STALL_START),
    .STALL_LEN    (STALL_LEN),
    .DOT_W        (DOT_W),
    .LINE_W       (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_blank (force_blank),
    .line        (line),
    .dot         (dot),
    .visible     (visible),
    .vblank      (vblank),
    .cpu_stall   (cpu_stall),
    .field       (field)
);

// File: tb/tb_scan_timing_gen.sv
// Bench: a reduced-size instance compared every clock with a behavioural
// model, plus a default-size instance measured over its first line.
module tb_scan_timing_gen;

    localparam int MPD = 4;
    localparam int DPL = 20;
    localparam int L60 = 14;
    localparam int L50 = 18;
    localparam int VS  = 6;
    localparam int VT  = 9;
    localparam int ADJ = 12;
    localparam int SS  = 30;
    localparam int SL  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pal_mode = 1'b0, tall_pic = 1'b0, interlace = 1'b0, force_blank = 1'b0;

    logic [8:0] line, dot, f_line, f_dot;
    logic       visible, vblank, cpu_stall, field;
    logic       f_visible, f_vblank, f_stall, f_field;

    int total = 0;
    int bad   = 0;
    bit checking = 1'b0;

    always #4 clk = ~clk;

    scan_timing_gen #(
        .MCLK_PER_DOT (MPD), .DOTS_PER_LINE (DPL), .LINES_60 (L60), .LINES_50 (L50),
        .VIS_SHORT (VS), .VIS_TALL (VT), .ADJ_LINE (ADJ),
        .STALL_START (SS), .STALL_LEN (SL), .DOT_W (9), .LINE_W (9)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pal_mode (pal_mode), .tall_pic (tall_pic),
        .interlace (interlace), .force_blank (force_blank),
        .line (line), .dot (dot), .visible (visible), .vblank (vblank),
        .cpu_stall (cpu_stall), .field (field)
    );

    scan_timing_gen dut_full (
        .clk (clk), .rst_n (rst_n), .pal_mode (1'b0), .tall_pic (1'b0),
        .interlace (1'b0), .force_blank (1'b0),
        .line (f_line), .dot (f_dot), .visible (f_visible), .vblank (f_vblank),
        .cpu_stall (f_stall), .field (f_field)
    );

    // Behavioural reference state
    int  m_pos, m_line;
    bit  m_field, m_pal, m_tall, m_il;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_line = 0; m_field = 0;
            m_pal = pal_mode; m_tall = tall_pic; m_il = interlace;
        end else begin
            int len, last;
            len = DPL * MPD;
            if (!m_il && m_line == ADJ) len = m_pal ? (DPL + 1) * MPD : (DPL - 1) * MPD;
            m_pos++;
            if (m_pos == len) begin
                m_pos = 0;
                last = (m_pal ? L50 : L60) - 1 + ((m_il && m_field) ? 1 : 0);
                if (m_line == last) begin
                    m_line = 0;
                    m_field = m_il ? !m_field : 1'b0;
                    m_pal = pal_mode; m_tall = tall_pic; m_il = interlace;
                end else m_line++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            if (bad < 30) $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the clock edge
    always @(negedge clk) begin
        if (checking) begin
            int vl;
            vl = m_tall ? VT : VS;
            chk("R6/R9 line", int'(line), m_line);
            chk((m_line == ADJ) ? "R8 dot" : "R1 dot", int'(dot), m_pos / MPD);
            chk((m_line == 0) ? "R3 visible" : "R4 visible", int'(visible),
                (m_line >= 1 && m_line <= vl && !force_blank) ? 1 : 0);
            chk((m_line == 0) ? "R3 vblank" : "R5 vblank", int'(vblank), (m_line > vl) ? 1 : 0);
            chk("R2 stall", int'(cpu_stall), (m_pos >= SS && m_pos < SS + SL) ? 1 : 0);
            chk("R7 field", int'(field), int'(m_field));
        end
    end

    task automatic set_modes(input bit p, input bit t, input bit il);
        @(posedge clk); #1;
        pal_mode = p; tall_pic = t; interlace = il;
    endtask

    // Watchdog
    initial begin
        #(8 * 190000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0, s_cnt, s_first;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 line", int'(line), 0);
        chk("R10 dot", int'(dot), 0);
        chk("R10 field", int'(field), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        checking = 1'b1;

        // Default-size line: length and stall window (R1, R2)
        n0 = 0; s_cnt = 0; s_first = -1;
        @(negedge clk);
        while (f_line == 9'd0 && n0 < 3000) begin
            if (f_stall) begin
                if (s_first < 0) begin
                    s_first = n0;
                    chk("R2 stall dot", int'(f_dot), 134);
                end
                s_cnt++;
            end
            n0++;
            @(negedge clk);
        end
        chk("R1 line length", n0, 1364);
        chk("R2 stall start", s_first, 536);
        chk("R2 stall length", s_cnt, 40);

        // 60 Hz short picture, odd short line (R8)
        repeat (2500) @(posedge clk);
        // R4: force blank mid-picture
        #1 force_blank = 1'b1;
        repeat (300) @(posedge clk);
        #1 force_blank = 1'b0;
        // R9: mid-frame change only applies at the wrap
        set_modes(1'b1, 1'b1, 1'b0);
        repeat (4500) @(posedge clk);
        // R7: interlace in 50 Hz
        set_modes(1'b1, 1'b1, 1'b1);
        repeat (8000) @(posedge clk);
        set_modes(1'b0, 1'b0, 1'b1);
        repeat (6000) @(posedge clk);
        #1 force_blank = 1'b1;
        repeat (57) @(posedge clk);
        #1 force_blank = 1'b0;
        set_modes(1'b0, 1'b1, 1'b0);
        repeat (3500) @(posedge clk);
        @(negedge clk);
        checking = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule